// File: doc/BRIEF.md
# Gated Block-Copy DMA Engine

This block moves a contiguous run of 32-bit words between system memory and a graphics memory region in one shot. Software programs a system-side byte address, a graphics-side byte address, a byte length and a direction bit through a small register write port. It then writes a start register. The engine shows that it is busy, copies the words one at a time through a word-wide request/acknowledge memory port, and finally updates a set of channel result registers and pulses a completion interrupt.

Before any data moves, the engine compares a global DMA controller configuration word, taken through a parameterised mask, against one exact value. If the masked word differs, the transfer is refused. Nothing is read or written, no interrupt is raised, the channel result registers keep their values and the busy status drops again. When a transfer finishes, the channel source register holds the system start address plus the length. The transfer-end flag is set and the transfer count reads zero.

Top module: `blkcopy_dma`

## Requirements
- R1: Register writes use word addresses 0 = system address, 1 = graphics address, 2 = byte length, 3 = direction (bit 0), 4 = start. A write to address 4 with bit 0 set, made while idle, drives `busy` to 1 on the next clock. A write to address 4 with bit 0 clear has no effect.
- R2: A transfer proceeds only if (`dmac_cfg` & CFG_MASK) == CFG_MATCH, with defaults 0x0000_8307 and 0x0000_8201. Bits outside the mask do not matter. On a mismatch there is no memory access and no interrupt, `ch_src_addr`, `ch_end_flag` and `ch_count` are unchanged, and `busy` returns to 0 two clocks after the start write.
- R3: With direction 0, each word is read from system memory (`mem_gfx` = 0) and written to graphics memory (`mem_gfx` = 1), at ascending addresses.
- R4: With direction 1, each word is read from graphics memory and written to system memory, at ascending addresses.
- R5: On completion, `ch_src_addr` equals the programmed system address plus the length, whatever the direction.
- R6: On completion, `ch_end_flag` is 1 and `ch_count` is 0.
- R7: `busy` returns to 0 at the end of an accepted transfer.
- R8: `irq_done` is high for exactly one clock per accepted transfer.
- R9: Each word takes one read access and then one write access. Each access holds `mem_req`, `mem_we`, `mem_gfx` and `mem_addr` steady until `mem_ack`. Length bits [1:0] are ignored, so a transfer of L bytes makes exactly 2*(L/4) accesses.
- R10: A start write that arrives while `busy` is 1 is ignored.
- R11: A zero length makes no memory access but completes with the same register updates and the same interrupt.
- R12: One clock after an accepted gate check, `ch_count` holds the word count (length/4) and `ch_end_flag` is 0. The count then decrements after each completed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| dmac_cfg | input | 32 | Global DMA controller configuration word |
| busy | output | 1 | Start/status: 1 while a transfer is active |
| irq_done | output | 1 | One-clock completion interrupt |
| ch_src_addr | output | AW | Channel source address result |
| ch_end_flag | output | 1 | Channel transfer-end flag |
| ch_count | output | LEN_W-2 | Channel remaining word count |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_gfx | output | 1 | 1 = graphics memory, 0 = system memory |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access acknowledge |

## Verification
Copies run in both directions, with an immediate acknowledge and with a stalling one. The stalled runs show whether the request stays steady and whether the data is taken only on acknowledge. The configuration word is tried at the exact match value, with a stray bit outside the mask, and with a bit of the match value cleared. This separates the gate's masking from a full-word compare. A zero length, a start write with bit 0 clear and a second start while busy each probe one edge of the start logic. In each case the memory contents, the access count and the interrupt count tell apart a real transfer from a false one.

// File: rtl/blkcopy_dma_pkg.sv
// Package: shared types and register word addresses for the block-copy DMA.
// Assumes a 3-bit register word address space.
package blkcopy_dma_pkg;
    localparam logic [2:0] RA_SYS   = 3'd0;
    localparam logic [2:0] RA_GFX   = 3'd1;
    localparam logic [2:0] RA_LEN   = 3'd2;
    localparam logic [2:0] RA_DIR   = 3'd3;
    localparam logic [2:0] RA_START = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD,
        ST_WR,
        ST_DONE
    } xfer_state_t;
endpackage

// File: rtl/blkcopy_dma_regs.sv
// Setup register file: holds the system address, the graphics address, the
// byte length (low two bits forced to zero) and the direction. It also decodes
// the start strobe. Assumes single-cycle write strobes.
module blkcopy_dma_regs
    import blkcopy_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [AW-1:0]    set_sys,
    output logic [AW-1:0]    set_gfx,
    output logic [LEN_W-1:0] set_len,
    output logic             set_dir,
    output logic             start_req
);
    // Capture setup values from software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_sys <= '0;
            set_gfx <= '0;
            set_len <= '0;
            set_dir <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_SYS: set_sys <= reg_wdata[AW-1:0];
                RA_GFX: set_gfx <= reg_wdata[AW-1:0];
                RA_LEN: set_len <= {reg_wdata[LEN_W-1:2], 2'b00};
                RA_DIR: set_dir <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // Start request: a write to the start address with bit 0 set.
    always_comb begin
        start_req = reg_wr && (reg_addr == RA_START) && reg_wdata[0];
    end
endmodule

// File: rtl/blkcopy_dma_gate.sv
// Configuration gate: compares the masked global controller word against one
// exact value. Purely combinational; it is sampled by the transfer FSM in its
// check state.
module blkcopy_dma_gate #(
    parameter logic [31:0] CFG_MASK  = 32'h0000_8307,
    parameter logic [31:0] CFG_MATCH = 32'h0000_8201
) (
    input  logic [31:0] dmac_cfg,
    output logic        cfg_ok
);
    // Exact masked match.
    always_comb begin
        cfg_ok = ((dmac_cfg & CFG_MASK) == CFG_MATCH);
    end
endmodule

// File: rtl/blkcopy_dma_xfer.sv
// Transfer engine: latches the setup on an idle start, runs the gate check,
// then moves one word per read/write access pair. It finishes by loading the
// channel result registers and pulsing the interrupt for one clock.
// Assumes the memory returns read data in the same cycle as mem_ack.
module blkcopy_dma_xfer
    import blkcopy_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             cfg_ok,
    input  logic [AW-1:0]    set_sys,
    input  logic [AW-1:0]    set_gfx,
    input  logic [LEN_W-1:0] set_len,
    input  logic             set_dir,
    output logic             busy,
    output logic             irq_done,
    output logic [AW-1:0]    ch_src_addr,
    output logic             ch_end_flag,
    output logic [LEN_W-3:0] ch_count,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_gfx,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack
);
    localparam int CW = LEN_W - 2;
    localparam logic [AW-1:0] WORD_STEP = AW'(4);

    xfer_state_t      state;
    logic [AW-1:0]    sys_base;
    logic [LEN_W-1:0] len_q;
    logic [AW-1:0]    src_ptr;
    logic [AW-1:0]    dst_ptr;
    logic             src_gfx;
    logic [31:0]      data_q;
    logic [CW-1:0]    words;

    // Word count of the latched length.
    always_comb begin
        words = len_q[LEN_W-1:2];
    end

    // Sequencer and channel result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            busy        <= 1'b0;
            sys_base    <= '0;
            len_q       <= '0;
            src_ptr     <= '0;
            dst_ptr     <= '0;
            src_gfx     <= 1'b0;
            data_q      <= '0;
            ch_src_addr <= '0;
            ch_end_flag <= 1'b0;
            ch_count    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        busy     <= 1'b1;
                        sys_base <= set_sys;
                        len_q    <= set_len;
                        src_gfx  <= set_dir;
                        src_ptr  <= set_dir ? set_gfx : set_sys;
                        dst_ptr  <= set_dir ? set_sys : set_gfx;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!cfg_ok) begin
                        busy  <= 1'b0;
                        state <= ST_IDLE;
                    end else begin
                        ch_end_flag <= 1'b0;
                        ch_count    <= words;
                        state       <= (words == '0) ? ST_DONE : ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_ack) begin
                        data_q <= mem_rdata;
                        state  <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_ack) begin
                        src_ptr  <= src_ptr + WORD_STEP;
                        dst_ptr  <= dst_ptr + WORD_STEP;
                        ch_count <= ch_count - CW'(1);
                        state    <= (ch_count == CW'(1)) ? ST_DONE : ST_RD;
                    end
                end
                ST_DONE: begin
                    ch_src_addr <= sys_base + AW'(len_q);
                    ch_end_flag <= 1'b1;
                    ch_count    <= '0;
                    busy        <= 1'b0;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive and completion pulse.
    always_comb begin
        mem_req   = (state == ST_RD) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_gfx   = (state == ST_RD) ? src_gfx : !src_gfx;
        mem_addr  = (state == ST_RD) ? src_ptr : dst_ptr;
        mem_wdata = data_q;
        irq_done  = (state == ST_DONE);
    end
endmodule

// File: rtl/blkcopy_dma.sv
// Top of the gated block-copy DMA: joins the setup registers, the
// configuration gate and the transfer engine. Synchronous active-low reset.
module blkcopy_dma #(
    parameter int          AW        = 32,
    parameter int          LEN_W     = 16,
    parameter logic [31:0] CFG_MASK  = 32'h0000_8307,
    parameter logic [31:0] CFG_MATCH = 32'h0000_8201
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    input  logic [31:0]      dmac_cfg,
    output logic             busy,
    output logic             irq_done,
    output logic [AW-1:0]    ch_src_addr,
    output logic             ch_end_flag,
    output logic [LEN_W-3:0] ch_count,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_gfx,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack
);
    logic [AW-1:0]    set_sys;
    logic [AW-1:0]    set_gfx;
    logic [LEN_W-1:0] set_len;
    logic             set_dir;
    logic             start_req;
    logic             cfg_ok;

    blkcopy_dma_regs #(.AW(AW), .LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .set_sys   (set_sys),
        .set_gfx   (set_gfx),
        .set_len   (set_len),
        .set_dir   (set_dir),
        .start_req (start_req)
    );

    blkcopy_dma_gate #(.CFG_MASK(CFG_MASK), .CFG_MATCH(CFG_MATCH)) u_gate (
        .dmac_cfg (dmac_cfg),
        .cfg_ok   (cfg_ok)
    );

    blkcopy_dma_xfer #(.AW(AW), .LEN_W(LEN_W)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .cfg_ok      (cfg_ok),
        .set_sys     (set_sys),
        .set_gfx     (set_gfx),
        .set_len     (set_len),
        .set_dir     (set_dir),
        .busy        (busy),
        .irq_done    (irq_done),
        .ch_src_addr (ch_src_addr),
        .ch_end_flag (ch_end_flag),
        .ch_count    (ch_count),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_gfx     (mem_gfx),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack)
    );
endmodule

// File: rtl/blkcopy_dma_chk.sv
// Checker: port-level temporal properties of the block-copy DMA, bound to
// the top module. Assumes the synchronous active-low reset of the top.
module blkcopy_dma_chk #(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             busy,
    input logic             irq_done,
    input logic             ch_end_flag,
    input logic [LEN_W-3:0] ch_count,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_gfx,
    input logic [AW-1:0]    mem_addr,
    input logic             mem_ack
);
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd4 && reg_wdata[0] && !busy) |=> busy); // R1
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R2
    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> (ch_end_flag && ch_count == '0)); // R6
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !busy); // R7
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_gfx))); // R9
endmodule

bind blkcopy_dma blkcopy_dma_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .busy        (busy),
    .irq_done    (irq_done),
    .ch_end_flag (ch_end_flag),
    .ch_count    (ch_count),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_gfx     (mem_gfx),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack)
);

// File: tb/blkcopy_dma_tb.sv
// Directed bench for the block-copy DMA: one task per scenario, each checking
// its own results against values derived from the requirements.
module blkcopy_dma_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      dmac_cfg = 32'h0000_8201;
    logic             busy;
    logic             irq_done;
    logic [AW-1:0]    ch_src_addr;
    logic             ch_end_flag;
    logic [LEN_W-3:0] ch_count;
    logic             mem_req;
    logic             mem_we;
    logic             mem_gfx;
    logic [AW-1:0]    mem_addr;
    logic [31:0]      mem_wdata;
    logic [31:0]      mem_rdata = '0;
    logic             mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int acc_cnt = 0;
    int irq_cnt = 0;
    int long_irq = 0;
    logic irq_prev = 1'b0;
    logic slow = 1'b0;
    logic [1:0] lat = '0;
    logic [31:0] sys_mem [0:255];
    logic [31:0] gfx_mem [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    blkcopy_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .dmac_cfg(dmac_cfg), .busy(busy),
        .irq_done(irq_done), .ch_src_addr(ch_src_addr), .ch_end_flag(ch_end_flag),
        .ch_count(ch_count), .mem_req(mem_req), .mem_we(mem_we), .mem_gfx(mem_gfx),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    // Memory model: acknowledges after 0 or 2 wait cycles, counts accesses.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (rst_n && mem_req && !mem_ack) begin
            if (lat == 2'd0) begin
                mem_ack <= 1'b1;
                acc_cnt <= acc_cnt + 1;
                lat     <= slow ? 2'd2 : 2'd0;
                if (mem_we) begin
                    if (mem_gfx) gfx_mem[mem_addr[9:2]] <= mem_wdata;
                    else         sys_mem[mem_addr[9:2]] <= mem_wdata;
                end else begin
                    mem_rdata <= mem_gfx ? gfx_mem[mem_addr[9:2]] : sys_mem[mem_addr[9:2]];
                end
            end else begin
                lat <= lat - 2'd1;
            end
        end
    end

    // Interrupt monitor: pulse count and over-long pulses.
    always @(posedge clk) begin
        irq_prev <= irq_done;
        if (rst_n && irq_done) begin
            irq_cnt <= irq_cnt + 1;
            if (irq_prev) long_irq <= long_irq + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] g,
                         input logic [31:0] l, input logic d);
        wr_reg(3'd0, s); wr_reg(3'd1, g); wr_reg(3'd2, l); wr_reg(3'd3, {31'd0, d});
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(irq_done == 1'b0 && mem_req == 1'b0, "R8 quiet after reset", {irq_done, mem_req}, 0);
        chk(ch_end_flag == 1'b0 && ch_count == '0 && ch_src_addr == '0, "R6 results after reset",
            ch_src_addr, 0);
    endtask

    task automatic t_start_bit_clear();
        int a0 = acc_cnt;
        setup(32'h100, 32'h040, 32'd8, 1'b0);
        wr_reg(3'd4, 32'h2);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && acc_cnt == a0, "R1 start bit0 clear ignored", acc_cnt - a0, 0);
    endtask

    task automatic t_copy_s2g();
        int a0 = acc_cnt;
        int i0 = irq_cnt;
        bit ok = 1'b1;
        slow = 1'b0;
        dmac_cfg = 32'h0000_8201;
        setup(32'h100, 32'h040, 32'd16, 1'b0);
        wr_reg(3'd4, 32'h1);
        chk(busy == 1'b1, "R1 busy after start", busy, 1);
        @(negedge clk);
        chk(ch_count == 14'd4 && ch_end_flag == 1'b0, "R12 count loaded", ch_count, 4);
        wait_idle();
        @(negedge clk);
        for (int k = 0; k < 4; k++) if (gfx_mem[16+k] != 32'hA000_0040 + k) ok = 1'b0;
        chk(ok, "R3 system to graphics data", gfx_mem[16], 32'hA000_0040);
        chk(ch_src_addr == 32'h110, "R5 source end address", ch_src_addr, 32'h110);
        chk(ch_end_flag && ch_count == '0, "R6 end flag and count", ch_count, 0);
        chk(busy == 1'b0, "R7 busy cleared", busy, 0);
        chk(irq_cnt == i0 + 1, "R8 one interrupt", irq_cnt - i0, 1);
        chk(acc_cnt == a0 + 8, "R9 access count", acc_cnt - a0, 8);
    endtask

    task automatic t_copy_g2s_slow();
        int a0 = acc_cnt;
        bit ok = 1'b1;
        slow = 1'b1;
        dmac_cfg = 32'h0000_8209;
        setup(32'h200, 32'h0C0, 32'd23, 1'b1);
        wr_reg(3'd4, 32'h1);
        wait_idle();
        @(negedge clk);
        for (int k = 0; k < 5; k++) if (sys_mem[128+k] != 32'h5000_0030 + k) ok = 1'b0;
        chk(ok, "R4 graphics to system data", sys_mem[128], 32'h5000_0030);
        chk(sys_mem[133] == 32'hA000_0085, "R9 no sixth word", sys_mem[133], 32'hA000_0085);
        chk(acc_cnt == a0 + 10, "R9 length low bits ignored", acc_cnt - a0, 10);
        chk(ch_src_addr == 32'h214, "R5 end address dir 1", ch_src_addr, 32'h214);
        chk(ok, "R2 bit outside mask accepted", ok, 1);
        slow = 1'b0;
    endtask

    task automatic t_refused();
        int a0 = acc_cnt;
        int i0 = irq_cnt;
        dmac_cfg = 32'h0000_8200;
        setup(32'h300, 32'h080, 32'd8, 1'b0);
        wr_reg(3'd4, 32'h1);
        @(negedge clk);
        chk(busy == 1'b0, "R2 busy drops on refusal", busy, 0);
        repeat (4) @(negedge clk);
        chk(acc_cnt == a0 && irq_cnt == i0, "R2 nothing moved", acc_cnt - a0, 0);
        chk(ch_src_addr == 32'h214 && ch_end_flag, "R2 results unchanged", ch_src_addr, 32'h214);
        dmac_cfg = 32'h0000_8201;
    endtask

    task automatic t_zero_len();
        int a0 = acc_cnt;
        int i0 = irq_cnt;
        setup(32'h180, 32'h000, 32'd0, 1'b0);
        wr_reg(3'd4, 32'h1);
        wait_idle();
        @(negedge clk);
        chk(acc_cnt == a0, "R11 zero length no access", acc_cnt - a0, 0);
        chk(irq_cnt == i0 + 1, "R11 zero length interrupt", irq_cnt - i0, 1);
        chk(ch_src_addr == 32'h180 && ch_end_flag && ch_count == '0, "R11 zero length results",
            ch_src_addr, 32'h180);
    endtask

    task automatic t_busy_restart();
        int a0 = acc_cnt;
        int i0 = irq_cnt;
        slow = 1'b1;
        setup(32'h100, 32'h200, 32'd12, 1'b0);
        wr_reg(3'd4, 32'h1);
        wr_reg(3'd4, 32'h1);
        repeat (3) @(negedge clk);
        wr_reg(3'd4, 32'h1);
        wait_idle();
        repeat (6) @(negedge clk);
        chk(irq_cnt == i0 + 1, "R10 restart while busy ignored", irq_cnt - i0, 1);
        chk(acc_cnt == a0 + 6, "R10 single transfer of accesses", acc_cnt - a0, 6);
        chk(gfx_mem[130] == 32'hA000_0042, "R3 last word copied", gfx_mem[130], 32'hA000_0042);
        slow = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            sys_mem[i] = 32'hA000_0000 + i;
            gfx_mem[i] = 32'h5000_0000 + i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_bit_clear();
        t_copy_s2g();
        t_copy_g2s_slow();
        t_refused();
        t_zero_len();
        t_busy_restart();
        chk(long_irq == 0, "R8 interrupt never longer than one clock", long_irq, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule